// File: doc/BRIEF.md
# Predicated Byte-Narrowing Store Sequencer

This block carries out one predicated contiguous store of a vector register, one byte per element. A command supplies the vector value, the predicate value, a 64-bit base, a 64-bit index, a 2-bit element-size code and the two register numbers that name the base and the index. The block walks the elements in ascending order. For each element whose predicate bit is set, it issues one single-byte write on a valid/ready port. The data is the low byte of the element. The address is the base plus the index plus the element number. The index is only read and never written back.

Before any write, the command is screened in two ways. An index register number of 31 is an illegal encoding. A base register number of 31 selects the stack pointer, which must be 16-byte aligned. When no element is active, a configuration bit decides whether the alignment screen still applies. Either outcome ends the command with a flag and no writes.

The controller has four states. `ST_IDLE` waits for `start` and takes the transition *accept* to `ST_CHECK`. `ST_CHECK` screens the command for one cycle and takes either *reject* to `ST_FINISH` or *launch* to `ST_WALK`. `ST_WALK` handles one element per step: it *skips* an inactive element in one cycle and *issues* an active one when the write is taken. It leaves through *drain* to `ST_FINISH` after the final element. `ST_FINISH` pulses `done` for one cycle and *returns* to `ST_IDLE`.

Top module: `bstore_seq`

## Requirements
- R1: The size code sets the element width to 8 << code bits (code 0 = 8, 1 = 16, 2 = 32, 3 = 64), and the element count is VLEN divided by that width.
- R2: Element e is active when predicate bit e << code is set. An inactive element produces no write.
- R3: The data of each write is bits [7:0] of its element, that is, vector bits starting at e × width.
- R4: The write address of element e is base + index + e, modulo 2^64. Inactive elements still use up their address slot.
- R5: Writes leave in ascending element order, at most one per cycle. While `wr_valid` is high and `wr_ready` is low, the address and data stay stable.
- R6: An index register number of 31 raises `illegal` and produces no writes.
- R7: A base register number of 31 with base[3:0] not zero and at least one active element raises `align_fault` and produces no writes.
- R8: With a base register number of 31, a misaligned base and no active element, `align_fault` is raised only when `chk_empty` is 1. Otherwise the command ends cleanly.
- R9: `done` is high for exactly one cycle, one cycle after the last element is handled, even when no element is active. With no stalls this is element count + 1 cycles after the start edge, or 1 cycle after it for a rejected command. `busy` is high from the cycle after `start` until `done`, and it is low after `done`.
- R10: After reset, `busy`, `done`, `wr_valid`, `illegal` and `align_fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a command while idle |
| vec_in | input | VLEN | Vector register value |
| pred_in | input | VLEN/8 | Predicate value, one bit per vector byte |
| base_in | input | 64 | Base address |
| index_in | input | 64 | Element index offset |
| size_in | input | 2 | Element-size code |
| rm_num | input | 5 | Index register number |
| rn_num | input | 5 | Base register number (31 = stack pointer) |
| chk_empty | input | 1 | Apply the alignment screen even when no element is active |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Encoding rejected; held until the next start |
| align_fault | output | 1 | Stack pointer misaligned; held until the next start |
| wr_valid | output | 1 | Byte write offered |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | 64 | Byte write address |
| wr_data | output | 8 | Byte write data |

## Verification
The bench goes after the wide-element cases, where a design that scaled the predicate step or the address step by the element width would test the wrong bits or spread its writes over the wrong addresses. It targets an index close to 2^64, where any truncated adder would write far from the wrapped address. It covers the empty-predicate stack-pointer case under both settings of the configuration bit, which a design that ignored the bit would fault on or let through wrongly. Random backpressure exposes designs that move the address or data while a write waits, and cycle counts catch a `done` that comes early, comes late or lasts two cycles. Each case runs on a 256-bit and a 128-bit instance.

// File: rtl/bstore_pkg.sv
package bstore_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WALK,
        ST_FINISH
    } bs_state_t;

    localparam logic [4:0] REG_NUM_SPECIAL = 5'd31;
    localparam int         SP_ALIGN_BITS   = 4;
endpackage

// File: rtl/bstore_elem_sel.sv
module bstore_elem_sel #(
    parameter int VLEN = 256,
    parameter int IW   = $clog2(VLEN / 8)
) (
    input  logic [VLEN-1:0]   vec_i,
    input  logic [VLEN/8-1:0] pred_i,
    input  logic [1:0]        size_i,
    input  logic [IW-1:0]     idx_i,
    output logic [7:0]        byte_o,
    output logic              act_o
);
    localparam int PW  = VLEN / 8;
    localparam int SHW = $clog2(VLEN) + 4;

    logic [7:0] byte_s [4];
    logic [3:0] act_s;

    // One selector per element width; the size code picks among them.
    for (genvar s = 0; s < 4; s++) begin : g_sz
        logic [VLEN-1:0] shifted;
        logic [PW-1:0]   pshift;
        assign shifted   = vec_i >> (SHW'(idx_i) << (s + 3));
        assign pshift    = pred_i >> (SHW'(idx_i) << s);
        assign byte_s[s] = shifted[7:0];
        assign act_s[s]  = pshift[0];
    end

    assign byte_o = byte_s[size_i];
    assign act_o  = act_s[size_i];
endmodule

// File: rtl/bstore_any_active.sv
module bstore_any_active #(
    parameter int PW = 32
) (
    input  logic [PW-1:0] pred_i,
    input  logic [1:0]    size_i,
    output logic          any_o
);
    logic [PW-1:0] hit_s [4];
    logic [3:0]    any_s;

    // Only every (1 << s)-th predicate bit governs an element.
    for (genvar s = 0; s < 4; s++) begin : g_sz
        for (genvar i = 0; i < PW; i++) begin : g_bit
            if ((i % (1 << s)) == 0) begin : g_on
                assign hit_s[s][i] = pred_i[i];
            end else begin : g_off
                assign hit_s[s][i] = 1'b0;
            end
        end
        assign any_s[s] = |hit_s[s];
    end

    assign any_o = any_s[size_i];
endmodule

// File: rtl/bstore_seq.sv
module bstore_seq
    import bstore_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VLEN-1:0]   vec_in,
    input  logic [VLEN/8-1:0] pred_in,
    input  logic [63:0]       base_in,
    input  logic [63:0]       index_in,
    input  logic [1:0]        size_in,
    input  logic [4:0]        rm_num,
    input  logic [4:0]        rn_num,
    input  logic              chk_empty,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              align_fault,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [63:0]       wr_addr,
    output logic [7:0]        wr_data
);
    localparam int PW = VLEN / 8;
    localparam int IW = $clog2(PW);

    bs_state_t         state_q, state_d;
    logic [IW-1:0]     elem_q;
    logic [VLEN-1:0]   vec_q;
    logic [PW-1:0]     pred_q;
    logic [63:0]       base_q, idx_q;
    logic [1:0]        size_q;
    logic [4:0]        rm_q, rn_q;
    logic              chk_q;
    logic              illegal_q, fault_q;

    logic              cur_act, any_act;
    logic [7:0]        cur_byte;
    logic              bad_enc, sp_mis, fault_now, last_elem, step;
    logic [IW-1:0]     last_idx;

    bstore_elem_sel #(.VLEN(VLEN), .IW(IW)) u_sel (
        .vec_i  (vec_q),
        .pred_i (pred_q),
        .size_i (size_q),
        .idx_i  (elem_q),
        .byte_o (cur_byte),
        .act_o  (cur_act)
    );

    bstore_any_active #(.PW(PW)) u_any (
        .pred_i (pred_q),
        .size_i (size_q),
        .any_o  (any_act)
    );

    assign bad_enc   = (rm_q == REG_NUM_SPECIAL);
    assign sp_mis    = (rn_q == REG_NUM_SPECIAL) && (base_q[SP_ALIGN_BITS-1:0] != '0);
    assign fault_now = !bad_enc && sp_mis && (any_act || chk_q);
    assign last_idx  = IW'((PW >> size_q) - 1);
    assign last_elem = (elem_q == last_idx);
    assign step      = (state_q == ST_WALK) && (!cur_act || wr_ready);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = (bad_enc || fault_now) ? ST_FINISH : ST_WALK;
            ST_WALK:   if (step && last_elem) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            vec_q     <= '0;
            pred_q    <= '0;
            base_q    <= '0;
            idx_q     <= '0;
            size_q    <= '0;
            rm_q      <= '0;
            rn_q      <= '0;
            chk_q     <= 1'b0;
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                vec_q     <= vec_in;
                pred_q    <= pred_in;
                base_q    <= base_in;
                idx_q     <= index_in;
                size_q    <= size_in;
                rm_q      <= rm_num;
                rn_q      <= rn_num;
                chk_q     <= chk_empty;
                illegal_q <= 1'b0;
                fault_q   <= 1'b0;
            end
            if (state_q == ST_CHECK) begin
                elem_q    <= '0;
                illegal_q <= bad_enc;
                fault_q   <= fault_now;
            end
            if (step && !last_elem) elem_q <= elem_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FINISH);
        wr_valid = (state_q == ST_WALK) && cur_act;
        wr_addr  = base_q + idx_q + 64'(elem_q);
        wr_data  = cur_byte;
    end

    assign illegal     = illegal_q;
    assign align_fault = fault_q;
endmodule

// File: rtl/bstore_seq_chk.sv
module bstore_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic        align_fault,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [7:0]  wr_data
);
    // R5: a stalled write keeps its address and data
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R6: a rejected encoding never writes
    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_valid);

    // R7: an alignment fault never writes
    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> !wr_valid);

    // R9: done is a single-cycle pulse that returns to idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9: an accepted start makes the block busy
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R10: writes only happen inside a command
    a_r10_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy && !done);
endmodule

bind bstore_seq bstore_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .illegal     (illegal),
    .align_fault (align_fault),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
);

// File: tb/bstore_seq_bench.sv
module bstore_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VA = 256;
    localparam int VB = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic            start = 1'b0;
    logic [VA-1:0]   vec = '0;
    logic [VA/8-1:0] pred = '0;
    logic [63:0]     base = '0, idx = '0;
    logic [1:0]      size = '0;
    logic [4:0]      rm = 5'd2, rn = 5'd1;
    logic            chk = 1'b0;
    logic            ready = 1'b1;
    logic            bp_en = 1'b0;

    logic busy_a, done_a, ill_a, flt_a, val_a;
    logic [63:0] addr_a;
    logic [7:0] data_a;
    logic busy_b, done_b, ill_b, flt_b, val_b;
    logic [63:0] addr_b;
    logic [7:0] data_b;

    bstore_seq #(.VLEN(VA)) u_bstore_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec), .pred_in(pred),
        .base_in(base), .index_in(idx), .size_in(size), .rm_num(rm), .rn_num(rn),
        .chk_empty(chk), .busy(busy_a), .done(done_a), .illegal(ill_a),
        .align_fault(flt_a), .wr_valid(val_a), .wr_ready(ready),
        .wr_addr(addr_a), .wr_data(data_a)
    );

    bstore_seq #(.VLEN(VB)) u_bstore_seq_n128 (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec[VB-1:0]),
        .pred_in(pred[VB/8-1:0]), .base_in(base), .index_in(idx), .size_in(size),
        .rm_num(rm), .rn_num(rn), .chk_empty(chk), .busy(busy_b), .done(done_b),
        .illegal(ill_b), .align_fault(flt_b), .wr_valid(val_b), .wr_ready(ready),
        .wr_addr(addr_b), .wr_data(data_b)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 ready <= bp_en ? 1'($urandom % 2) : 1'b1;
    end

    // Observed writes and completion, sampled on the falling edge
    logic [63:0] ga_addr [256];
    logic [7:0]  ga_data [256];
    logic [63:0] gb_addr [256];
    logic [7:0]  gb_data [256];
    int ga_n, gb_n, da_n, db_n, da_cyc, db_cyc, hold_err;
    logic        pa_stall, pb_stall;
    logic [71:0] pa_word, pb_word;

    always @(negedge clk) begin
        if (val_a && ready && ga_n < 256) begin
            ga_addr[ga_n] = addr_a; ga_data[ga_n] = data_a; ga_n++;
        end
        if (val_b && ready && gb_n < 256) begin
            gb_addr[gb_n] = addr_b; gb_data[gb_n] = data_b; gb_n++;
        end
        if (pa_stall && !(val_a && {addr_a, data_a} == pa_word)) hold_err++;
        if (pb_stall && !(val_b && {addr_b, data_b} == pb_word)) hold_err++;
        pa_stall = val_a && !ready; pa_word = {addr_a, data_a};
        pb_stall = val_b && !ready; pb_word = {addr_b, data_b};
        if (done_a) begin da_n++; da_cyc = cyc; end
        if (done_b) begin db_n++; db_cyc = cyc; end
    end

    // Reference expectation
    logic [63:0] ea_addr [256];
    logic [7:0]  ea_data [256];
    logic [63:0] eb_addr [256];
    logic [7:0]  eb_data [256];
    int ea_n, eb_n, nel_a, nel_b;
    logic ea_ill, ea_flt, eb_ill, eb_flt;

    task automatic build_exp(input int vl);
        int nel, n, w;
        logic any, ill, flt;
        logic [63:0] ad [256];
        logic [7:0]  dt [256];
        w   = 8 << size;                 // R1
        nel = vl / w;
        n   = 0;
        for (int e = 0; e < nel; e++) begin
            if (pred[e << size]) begin   // R2
                ad[n] = base + idx + 64'(e);     // R4
                dt[n] = vec[e * w +: 8];         // R3
                n++;
            end
        end
        any = (n != 0);
        ill = (rm == 5'd31);
        flt = !ill && rn == 5'd31 && base[3:0] != 4'h0 && (any || chk);
        if (ill || flt) n = 0;
        if (vl == VA) begin
            ea_n = n; nel_a = nel; ea_ill = ill; ea_flt = flt;
            for (int k = 0; k < n; k++) begin ea_addr[k] = ad[k]; ea_data[k] = dt[k]; end
        end else begin
            eb_n = n; nel_b = nel; eb_ill = ill; eb_flt = flt;
            for (int k = 0; k < n; k++) begin eb_addr[k] = ad[k]; eb_data[k] = dt[k]; end
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input string req);
        int st;
        int lat_a, lat_b;
        build_exp(VA);
        build_exp(VB);
        ga_n = 0; gb_n = 0; da_n = 0; db_n = 0; hold_err = 0;
        pa_stall = 1'b0; pb_stall = 1'b0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        st = cyc;
        for (int w = 0; w < 3000 && !(da_n > 0 && db_n > 0); w++) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R9", "done pulses (256)", 64'(da_n), 64'd1);
        check("R9", "done pulses (128)", 64'(db_n), 64'd1);
        check("R9", "idle after done", {62'd0, busy_a, busy_b}, 64'd0);
        check(req, "write count (256)", 64'(ga_n), 64'(ea_n));
        check(req, "write count (128)", 64'(gb_n), 64'(eb_n));
        for (int k = 0; k < ea_n && k < ga_n; k++) begin
            check(req, "addr (256)", ga_addr[k], ea_addr[k]);
            check(req, "data (256)", 64'(ga_data[k]), 64'(ea_data[k]));
        end
        for (int k = 0; k < eb_n && k < gb_n; k++) begin
            check(req, "addr (128)", gb_addr[k], eb_addr[k]);
            check(req, "data (128)", 64'(gb_data[k]), 64'(eb_data[k]));
        end
        check("R6", "illegal flag", {62'd0, ill_a, ill_b}, {62'd0, ea_ill, eb_ill});
        check("R7", "fault flag", {62'd0, flt_a, flt_b}, {62'd0, ea_flt, eb_flt});
        check("R5", "stall hold errors", 64'(hold_err), 64'd0);
        if (!bp_en) begin
            lat_a = (ea_ill || ea_flt) ? 1 : nel_a + 1;
            lat_b = (eb_ill || eb_flt) ? 1 : nel_b + 1;
            check("R9", "done latency (256)", 64'(da_cyc - st), 64'(lat_a));
            check("R9", "done latency (128)", 64'(db_cyc - st), 64'(lat_b));
        end
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    task automatic set_cmd(input logic [1:0] s, input logic [VA/8-1:0] p,
                           input logic [63:0] b, input logic [63:0] i);
        vec = '0;
        for (int k = 0; k < VA / 32; k++) vec[k * 32 +: 32] = $urandom;
        size = s; pred = p; base = b; idx = i; rm = 5'd3; rn = 5'd4; chk = 1'b0;
    endtask

    task automatic t_reset();
        check("R10", "outputs after reset",
              {59'd0, busy_a, done_a, val_a, ill_a, flt_a}, 64'd0);
        check("R10", "outputs after reset (128)",
              {59'd0, busy_b, done_b, val_b, ill_b, flt_b}, 64'd0);
    endtask

    task automatic t_all_bytes();
        set_cmd(2'd0, '1, 64'h1000, 64'h20);
        run_case("R3");
    endtask

    task automatic t_each_size();
        for (int s = 0; s < 4; s++) begin
            set_cmd(2'(s), '1, r64(), r64());
            run_case("R1");
        end
    endtask

    task automatic t_sparse();
        for (int s = 0; s < 4; s++) begin
            set_cmd(2'(s), 32'hA5C3_0F69, 64'h4000, 64'd5);
            run_case("R2");
        end
    endtask

    task automatic t_wrap();
        set_cmd(2'd0, '1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFD);
        run_case("R4");
        set_cmd(2'd1, 32'h5555_5555, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8);
        run_case("R4");
    endtask

    task automatic t_illegal();
        set_cmd(2'd0, '1, 64'h2000, 64'h1);
        rm = 5'd31;
        run_case("R6");
    endtask

    task automatic t_sp();
        set_cmd(2'd2, '1, 64'h3008, 64'h0);
        rn = 5'd31;
        run_case("R7");
        set_cmd(2'd0, '1, 64'h3010, 64'h2);
        rn = 5'd31;
        run_case("R7");
        set_cmd(2'd3, '0, 64'h3004, 64'h0);
        rn = 5'd31; chk = 1'b1;
        run_case("R8");
        set_cmd(2'd3, '0, 64'h3004, 64'h0);
        rn = 5'd31; chk = 1'b0;
        run_case("R8");
        set_cmd(2'd2, 32'h0000_00F0, 64'h3004, 64'h0);  // governing bits 0,4: bit 4 active
        rn = 5'd31; chk = 1'b0;
        run_case("R7");
    endtask

    task automatic t_backpressure();
        bp_en = 1'b1;
        for (int r = 0; r < 6; r++) begin
            set_cmd(2'($urandom % 4), {$urandom}, r64(), r64());
            run_case("R5");
        end
        bp_en = 1'b0;
    endtask

    task automatic t_random();
        for (int r = 0; r < 20; r++) begin
            set_cmd(2'($urandom % 4), {$urandom}, r64(), r64());
            if (r % 5 == 0) idx = 64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom % 8);
            run_case("R4");
        end
    endtask

    initial begin
        ga_n = 0; gb_n = 0; da_n = 0; db_n = 0; hold_err = 0;
        da_cyc = 0; db_cyc = 0;
        pa_stall = 1'b0; pb_stall = 1'b0; pa_word = '0; pb_word = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_bytes();
        t_each_size();
        t_sparse();
        t_wrap();
        t_illegal();
        t_sp();
        t_backpressure();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule